// File: doc/BRIEF.md
# Radar Pulse Event Classifier

This block examines one received PHY-error frame at a time and decides whether it carries a radar pulse event. The frame's header arrives on parallel inputs: an error-type code, three RSSI bytes (combined, control chain 0 and extension chain 0) and a 64-bit timestamp. These inputs are held steady while the payload streams in, one byte per cycle, with a valid strobe and a last strobe. The block never stores the whole payload. It keeps the first byte, the three most recent bytes and a saturating byte count.

One cycle after the last strobe, the block gives its decision. It raises either a single-cycle event-valid pulse, with an event record of timestamp, RSSI, pulse duration and channel flags, or a single-cycle reject pulse. Three static configuration inputs choose the mode of operation. Extension-channel mode reads a three-byte trailer. Enhanced mode applies margin-based RSSI rules. Combined-RSSI mode picks which header RSSI byte is the base value.

Top module: `radar_event_classifier`

## Requirements
- R1: A frame is accepted only when its error code equals the radar code (default 5) or the false-extension-radar code (default 24). Any other code produces a reject pulse.
- R2: Any RSSI byte with bit 7 set is treated as negative and replaced by zero before it is used or compared. A reported RSSI therefore never has bit 7 set.
- R3: The base RSSI is the combined byte when combined-RSSI mode is on, and the control-chain byte otherwise.
- R4: In extension-channel mode, a frame of fewer than 3 payload bytes is rejected. Otherwise the final three bytes are read as primary length, extension length and flag byte, in that order.
- R5: The flag byte uses bit 0 for primary found, bit 1 for extension found and bit 2 for early-extension found. In extension-channel mode, a flag byte of zero causes rejection.
- R6: When flag bits 0 and 1 are both set, the event is marked DC and the duration is the longer of the two lengths; a tie selects the primary length. The output flags use bit 0 for primary, bit 1 for extension, bit 2 for early and bit 3 for DC, and exactly one of bits 0 and 1 is set.
- R7: When the DC case does not apply, the duration rules are tried in this order. An early bit gives the extension length, with the extension and early flags set. Otherwise a primary bit gives the primary length with the primary flag set. Otherwise an extension bit gives the extension length with the extension flag set.
- R8: Outside extension-channel mode, the duration is payload byte 0, or zero for an empty payload. The frame is rejected when both the duration and the clamped base RSSI are zero. An accepted event carries only the primary flag.
- R9: In enhanced mode, flag bits [1:0] select the RSSI, and these bits count as zero outside extension-channel mode. A value of 0 gives RSSI zero. Primary only gives zero when the extension RSSI is at least the base RSSI plus 3, and the base RSSI otherwise. Extension only gives zero when the base RSSI is at least the extension RSSI plus 12, and the extension RSSI otherwise. Both bits set give the larger of the two.
- R10: In extension-channel mode without enhanced mode, the extension RSSI replaces the base RSSI when it is larger and below 128.
- R11: The valid or reject pulse appears in the cycle after the edge that samples the last strobe and lasts one cycle. The event timestamp equals the timestamp input at the last strobe. After reset, both pulses are low.
- R12: Each frame starts with a cleared byte count, so a frame that follows another with no gap is judged on its own bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ext_mode | input | 1 | Extension-channel mode (reads the three-byte trailer) |
| cfg_enh_mode | input | 1 | Enhanced RSSI selection rules |
| cfg_comb_rssi | input | 1 | Use the combined RSSI as the base value |
| err_code | input | 8 | Error-type code of the frame |
| rssi_comb | input | 8 | Combined RSSI byte |
| rssi_ctl | input | 8 | Control chain 0 RSSI byte |
| rssi_ext | input | 8 | Extension chain 0 RSSI byte |
| ts_in | input | 64 | Frame timestamp |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | Payload byte present this cycle |
| byte_last | input | 1 | Frame ends this cycle (may be raised without a byte for an empty payload) |
| evt_valid | output | 1 | Single-cycle accepted-event pulse |
| evt_reject | output | 1 | Single-cycle rejection pulse |
| evt_ts | output | 64 | Event timestamp |
| evt_rssi | output | 8 | Event RSSI |
| evt_dur | output | 8 | Event pulse duration |
| evt_flags | output | 4 | {dc, early, extension, primary} |

## Verification
Every result is registered once: the edge that samples the last strobe also loads the decision, so the record and the valid or reject pulse are due one cycle after that edge. The bench drives inputs on falling edges. It reads the pulse and the record on the falling edge that follows the sampling edge, and on the falling edge after that it confirms the pulse has dropped. In the back-to-back case, the first frame's result is read while the second frame's opening byte is already on the inputs, which shows that the decision does not wait for the bus to go idle.

// File: rtl/radar_pkg.sv
package radar_pkg;
    localparam int TAIL_LEN = 3;
    localparam int CNT_W    = $clog2(TAIL_LEN + 1);

    typedef struct packed {
        logic dc;
        logic early;
        logic ext;
        logic pri;
    } evt_flags_t;

    function automatic logic [7:0] clamp_neg(input logic [7:0] v);
        return v[7] ? 8'd0 : v;
    endfunction
endpackage

// File: rtl/radar_payload_tracker.sv
module radar_payload_tracker
    import radar_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    byte_data,
    input  logic             byte_valid,
    input  logic             byte_last,
    output logic [BW-1:0]    view_first,
    output logic [BW-1:0]    view_pri,
    output logic [BW-1:0]    view_ext,
    output logic [BW-1:0]    view_flag,
    output logic [CNT_W-1:0] view_cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TAIL_LEN);

    typedef struct packed {
        logic [BW-1:0]    first;
        logic [BW-1:0]    b0;
        logic [BW-1:0]    b1;
        logic [BW-1:0]    b2;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t s, trk_d, trk_q;

    always_comb begin
        s = trk_q;
        if (byte_valid) begin
            if (trk_q.cnt == '0) s.first = byte_data;
            s.b0 = trk_q.b1;
            s.b1 = trk_q.b2;
            s.b2 = byte_data;
            if (trk_q.cnt != CNT_SAT) s.cnt = trk_q.cnt + 1'b1;
        end
        trk_d = s;
        if (byte_last) trk_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign view_first = s.first;
    assign view_pri   = s.b0;
    assign view_ext   = s.b1;
    assign view_flag  = s.b2;
    assign view_cnt   = s.cnt;

    // R12
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |=> (trk_q.cnt == '0));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_last && trk_q.cnt != CNT_SAT) |=> (trk_q.cnt == $past(trk_q.cnt) + 1'b1));
endmodule

// File: rtl/radar_dur_pick.sv
module radar_dur_pick
    import radar_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [BW-1:0]    first,
    input  logic [BW-1:0]    pri_len,
    input  logic [BW-1:0]    ext_len,
    input  logic [BW-1:0]    flag,
    output logic [BW-1:0]    dur,
    output evt_flags_t       flags,
    output logic [1:0]       bw_bits,
    output logic             too_short,
    output logic             no_flag
);
    always_comb begin
        dur       = '0;
        flags     = '0;
        bw_bits   = 2'b00;
        too_short = 1'b0;
        no_flag   = 1'b0;
        if (ext_mode) begin
            too_short = (cnt < CNT_W'(TAIL_LEN));
            no_flag   = (flag == '0);
            bw_bits   = flag[1:0];
            if (flag[0] && flag[1]) begin
                flags.dc = 1'b1;
                if (ext_len > pri_len) begin
                    dur       = ext_len;
                    flags.ext = 1'b1;
                end else begin
                    dur       = pri_len;
                    flags.pri = 1'b1;
                end
            end else if (flag[2]) begin
                dur         = ext_len;
                flags.ext   = 1'b1;
                flags.early = 1'b1;
            end else if (flag[0]) begin
                dur       = pri_len;
                flags.pri = 1'b1;
            end else if (flag[1]) begin
                dur       = ext_len;
                flags.ext = 1'b1;
            end
        end else begin
            dur       = (cnt != '0) ? first : '0;
            flags.pri = 1'b1;
        end
    end
endmodule

// File: rtl/radar_rssi_pick.sv
module radar_rssi_pick #(
    parameter int RW         = 8,
    parameter int PRI_MARGIN = 3,
    parameter int EXT_MARGIN = 12
) (
    input  logic          ext_mode,
    input  logic          enh_mode,
    input  logic [1:0]    bw_bits,
    input  logic [RW-1:0] base_rssi,
    input  logic [RW-1:0] ext_rssi,
    output logic [RW-1:0] rssi
);
    localparam int WW = RW + 1;
    localparam logic [WW-1:0] POS_LIMIT = WW'(1) << (RW - 1);

    logic [WW-1:0] base_w, ext_w;

    always_comb begin
        base_w = {1'b0, base_rssi};
        ext_w  = {1'b0, ext_rssi};
        rssi   = base_rssi;
        if (enh_mode) begin
            case (bw_bits)
                2'b00: rssi = '0;
                2'b01: if (ext_w >= base_w + WW'(PRI_MARGIN)) rssi = '0;
                2'b10: rssi = (base_w >= ext_w + WW'(EXT_MARGIN)) ? '0 : ext_rssi;
                default: if (base_w < ext_w) rssi = ext_rssi;
            endcase
        end else if (ext_mode) begin
            if (ext_w > base_w && ext_w < POS_LIMIT) rssi = ext_rssi;
        end
    end
endmodule

// File: rtl/radar_event_classifier.sv
module radar_event_classifier
    import radar_pkg::*;
#(
    parameter int          BW            = 8,
    parameter int          TSW           = 64,
    parameter logic [7:0]  ERR_RADAR     = 8'd5,
    parameter logic [7:0]  ERR_FALSE_EXT = 8'd24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_ext_mode,
    input  logic           cfg_enh_mode,
    input  logic           cfg_comb_rssi,
    input  logic [7:0]     err_code,
    input  logic [BW-1:0]  rssi_comb,
    input  logic [BW-1:0]  rssi_ctl,
    input  logic [BW-1:0]  rssi_ext,
    input  logic [TSW-1:0] ts_in,
    input  logic [BW-1:0]  byte_data,
    input  logic           byte_valid,
    input  logic           byte_last,
    output logic           evt_valid,
    output logic           evt_reject,
    output logic [TSW-1:0] evt_ts,
    output logic [BW-1:0]  evt_rssi,
    output logic [BW-1:0]  evt_dur,
    output logic [3:0]     evt_flags
);
    typedef struct packed {
        logic           valid;
        logic           reject;
        logic [TSW-1:0] ts;
        logic [BW-1:0]  rssi;
        logic [BW-1:0]  dur;
        evt_flags_t     flags;
    } out_t;

    logic [BW-1:0]    v_first, v_pri, v_ext, v_flag;
    logic [CNT_W-1:0] v_cnt;
    logic [BW-1:0]    sel_dur, sel_rssi, base_c, ext_c;
    evt_flags_t       sel_flags;
    logic [1:0]       bw_bits;
    logic             too_short, no_flag, type_ok, drop;
    out_t             out_d, out_q;

    radar_payload_tracker #(.BW(BW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_last  (byte_last),
        .view_first (v_first),
        .view_pri   (v_pri),
        .view_ext   (v_ext),
        .view_flag  (v_flag),
        .view_cnt   (v_cnt)
    );

    radar_dur_pick #(.BW(BW)) u_dur (
        .ext_mode  (cfg_ext_mode),
        .cnt       (v_cnt),
        .first     (v_first),
        .pri_len   (v_pri),
        .ext_len   (v_ext),
        .flag      (v_flag),
        .dur       (sel_dur),
        .flags     (sel_flags),
        .bw_bits   (bw_bits),
        .too_short (too_short),
        .no_flag   (no_flag)
    );

    assign base_c = clamp_neg(cfg_comb_rssi ? rssi_comb : rssi_ctl);
    assign ext_c  = clamp_neg(rssi_ext);

    radar_rssi_pick #(.RW(BW)) u_rssi (
        .ext_mode  (cfg_ext_mode),
        .enh_mode  (cfg_enh_mode),
        .bw_bits   (bw_bits),
        .base_rssi (base_c),
        .ext_rssi  (ext_c),
        .rssi      (sel_rssi)
    );

    assign type_ok = (err_code == ERR_RADAR) || (err_code == ERR_FALSE_EXT);

    always_comb begin
        drop = !type_ok;
        if (cfg_ext_mode) drop = drop || too_short || no_flag;
        else              drop = drop || (sel_dur == '0 && base_c == '0);

        out_d        = out_q;
        out_d.valid  = 1'b0;
        out_d.reject = 1'b0;
        if (byte_last) begin
            if (drop) begin
                out_d.reject = 1'b1;
            end else begin
                out_d.valid = 1'b1;
                out_d.ts    = ts_in;
                out_d.rssi  = sel_rssi;
                out_d.dur   = sel_dur;
                out_d.flags = sel_flags;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign evt_valid  = out_q.valid;
    assign evt_reject = out_q.reject;
    assign evt_ts     = out_q.ts;
    assign evt_rssi   = out_q.rssi;
    assign evt_dur    = out_q.dur;
    assign evt_flags  = out_q.flags;

    // R11
    reply_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |=> (evt_valid ^ evt_reject));

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_last |=> (!evt_valid && !evt_reject));

    // R1
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_last && err_code != ERR_RADAR && err_code != ERR_FALSE_EXT) |=> evt_reject);

    // R6
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $onehot(evt_flags[1:0]));

    // R7
    early_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_flags[2]) |-> (evt_flags[1] && !evt_flags[3]));

    // R2
    rssi_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> !evt_rssi[BW-1]);

    // R8
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_last && !cfg_ext_mode) |=> (!evt_valid || evt_flags == 4'b0001));
endmodule

// File: tb/radar_event_classifier_test.sv
module radar_event_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ext_mode = 1'b0, cfg_enh_mode = 1'b0, cfg_comb_rssi = 1'b0;
    logic [7:0]  err_code = '0, rssi_comb = '0, rssi_ctl = '0, rssi_ext = '0;
    logic [63:0] ts_in = '0;
    logic [7:0]  byte_data = '0;
    logic        byte_valid = 1'b0, byte_last = 1'b0;
    logic        evt_valid, evt_reject;
    logic [63:0] evt_ts;
    logic [7:0]  evt_rssi, evt_dur;
    logic [3:0]  evt_flags;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    radar_event_classifier uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ext_mode(cfg_ext_mode), .cfg_enh_mode(cfg_enh_mode), .cfg_comb_rssi(cfg_comb_rssi),
        .err_code(err_code), .rssi_comb(rssi_comb), .rssi_ctl(rssi_ctl), .rssi_ext(rssi_ext),
        .ts_in(ts_in), .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
        .evt_valid(evt_valid), .evt_reject(evt_reject), .evt_ts(evt_ts),
        .evt_rssi(evt_rssi), .evt_dur(evt_dur), .evt_flags(evt_flags)
    );

    typedef struct packed {
        logic        ext;
        logic        enh;
        logic        comb;
        logic [7:0]  code;
        logic [7:0]  rc;
        logic [7:0]  rctl;
        logic [7:0]  rext;
        logic [2:0]  len;
        logic [31:0] pay;
        logic        ev;
        logic [7:0]  rssi;
        logic [7:0]  dur;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 21;
    // Payload byte k is pay[8k+:8]; flags are {dc, early, ext, pri}.
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,8'd5 ,8'd50,8'd30 ,8'd0 ,3'd1,32'h00000020,1'b1,8'd30 ,8'h20,4'h1}, // R8 basic
        '{1'b0,1'b0,1'b0,8'd7 ,8'd50,8'd30 ,8'd0 ,3'd1,32'h00000020,1'b0,8'd0  ,8'h00,4'h0}, // R1 bad code
        '{1'b0,1'b0,1'b1,8'd24,8'd40,8'd30 ,8'd0 ,3'd2,32'h00002211,1'b1,8'd40 ,8'h11,4'h1}, // R1 R3
        '{1'b0,1'b0,1'b0,8'd5 ,8'd0 ,8'h90 ,8'd0 ,3'd0,32'h00000000,1'b0,8'd0  ,8'h00,4'h0}, // R2 R8 empty
        '{1'b0,1'b0,1'b0,8'd5 ,8'd0 ,8'h85 ,8'd0 ,3'd1,32'h00000007,1'b1,8'd0  ,8'h07,4'h1}, // R2
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd2,32'h00000201,1'b0,8'd0  ,8'h00,4'h0}, // R4 short
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd3,32'h0000140A,1'b0,8'd0  ,8'h00,4'h0}, // R5 zero flag
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd4,32'h03281EAA,1'b1,8'd20 ,8'd40,4'hA}, // R4 R6
        '{1'b1,1'b0,1'b0,8'd24,8'd0 ,8'd20 ,8'd35,3'd3,32'h00031919,1'b1,8'd35 ,8'd25,4'h9}, // R6 tie R10
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'h88,3'd3,32'h0005210F,1'b1,8'd20 ,8'd33,4'h6}, // R7 early R2
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd3,32'h0001210F,1'b1,8'd20 ,8'd15,4'h1}, // R7 pri
        '{1'b1,1'b0,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd3,32'h0002210F,1'b1,8'd20 ,8'd33,4'h2}, // R7 ext
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd23,3'd3,32'h00010809,1'b1,8'd0  ,8'd9 ,4'h1}, // R9 +3 edge
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd22,3'd3,32'h00010809,1'b1,8'd20 ,8'd9 ,4'h1}, // R9
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd32 ,8'd20,3'd3,32'h00020809,1'b1,8'd0  ,8'd8 ,4'h2}, // R9 +12 edge
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd31 ,8'd20,3'd3,32'h00020809,1'b1,8'd20 ,8'd8 ,4'h2}, // R9
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd10 ,8'd40,3'd3,32'h00030809,1'b1,8'd40 ,8'd9 ,4'h9}, // R9 both
        '{1'b1,1'b1,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd3,32'h00040809,1'b1,8'd0  ,8'd8 ,4'h6}, // R9 bits 0
        '{1'b0,1'b1,1'b0,8'd5 ,8'd0 ,8'd20 ,8'd10,3'd0,32'h00000000,1'b1,8'd0  ,8'd0 ,4'h1}, // R8 R9
        '{1'b1,1'b0,1'b1,8'd5 ,8'd50,8'd5  ,8'd10,3'd3,32'h00010403,1'b1,8'd50 ,8'd3 ,4'h1}, // R3 ext
        '{1'b1,1'b0,1'b0,8'd24,8'd0 ,8'h7E ,8'h7F,3'd3,32'h00020302,1'b1,8'd127,8'd3 ,4'h2}  // R10
    };

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [2:0] len, input logic [31:0] pay);
        if (len == 0) begin
            @(negedge clk);
            byte_valid = 1'b0;
            byte_last  = 1'b1;
        end else begin
            for (int k = 0; k < int'(len); k++) begin
                @(negedge clk);
                byte_valid = 1'b1;
                byte_data  = pay[8*k +: 8];
                byte_last  = (k == int'(len) - 1);
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_last  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!evt_valid && !evt_reject, "R11 reset pulses", {evt_valid, evt_reject}, 0);
        check(evt_flags == 0 && evt_dur == 0, "R11 reset record", {evt_flags, evt_dur}, 0);

        for (int i = 0; i < NV; i++) begin
            cfg_ext_mode  = VECS[i].ext;
            cfg_enh_mode  = VECS[i].enh;
            cfg_comb_rssi = VECS[i].comb;
            err_code      = VECS[i].code;
            rssi_comb     = VECS[i].rc;
            rssi_ctl      = VECS[i].rctl;
            rssi_ext      = VECS[i].rext;
            ts_in         = 64'hABCD_0000_0000_1000 + 64'(i);
            send_frame(VECS[i].len, VECS[i].pay);
            $display("vector %0d", i);
            check(evt_valid == VECS[i].ev && evt_reject == !VECS[i].ev,
                  "R1/R4/R5/R8 decision", {evt_valid, evt_reject}, {VECS[i].ev, !VECS[i].ev});
            if (VECS[i].ev) begin
                check(evt_rssi == VECS[i].rssi, "R2/R3/R9/R10 rssi", evt_rssi, VECS[i].rssi);
                check(evt_dur == VECS[i].dur, "R6/R7/R8 dur", evt_dur, VECS[i].dur);
                check(evt_flags == VECS[i].fl, "R6/R7/R8 flags", evt_flags, VECS[i].fl);
                check(evt_ts == 64'hABCD_0000_0000_1000 + 64'(i), "R11 ts", evt_ts,
                      64'hABCD_0000_0000_1000 + 64'(i));
            end
            @(negedge clk);
            check(!evt_valid && !evt_reject, "R11 single-cycle pulse", {evt_valid, evt_reject}, 0);
        end

        // R12: back-to-back frames, second one too short on its own
        cfg_ext_mode = 1'b1; cfg_enh_mode = 1'b0; cfg_comb_rssi = 1'b0;
        err_code = 8'd5; rssi_ctl = 8'd20; rssi_ext = 8'd10; ts_in = 64'h77;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = (k == 0) ? 8'd7 : (k == 3) ? 8'd1 : 8'(k);
            byte_last  = (k == 3);
        end
        @(negedge clk);
        byte_data = 8'd5; byte_last = 1'b0;
        check(evt_valid && evt_dur == 8'd1 && evt_flags == 4'h1, "R12 first frame",
              {evt_valid, evt_dur, evt_flags}, {1'b1, 8'd1, 4'h1});
        @(negedge clk);
        byte_data = 8'd6; byte_last = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; byte_last = 1'b0;
        check(evt_reject && !evt_valid, "R12 second frame rejected", {evt_valid, evt_reject}, 2'b01);

        // R11 reset mid-frame clears pending state: outputs stay low
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'd9;
        @(negedge clk);
        rst_n = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!evt_valid && !evt_reject && evt_dur == 0, "R11 reset mid-frame",
              {evt_valid, evt_reject, evt_dur}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule